// File: doc/BRIEF.md
# UART Channel Register and Command Controller

This block is the byte-wide register front end of one UART channel. A host reaches it through a 6-bit offset bus with separate read and write strobes. It keeps the channel's control state: two mode registers behind one shared offset, an interrupt mask, the enables of both directions and a one-byte transmit holding register. It also decodes a packed command byte, which can reset parts of the channel and switch either direction on or off.

The serializer, the baud generator and the receive FIFO storage sit outside the block. A byte that is ready to go is handed to the serializer as a one-cycle valid pulse. The FIFO reports its empty flag, its full flag, its head byte and its error flags. The block answers with pop and flush pulses. The two baud-divider bytes are fixed by parameters and can only be read. One level-sensitive interrupt output is formed from the interrupt status and the mask.

Top module: `uart_ctl_core`

## Requirements
- R1: After reset the status reads 0x08 while the FIFO is empty and has no error flags. Both mode registers, the interrupt mask and the interrupt status are zero. Both directions are disabled, and `irq`, `tx_valid`, `rx_pop` and `rx_flush` are low.
- R2: Offset 0x00 accesses the mode register that the pointer selects. Any write there leaves the pointer at 1. A command whose bits [5:4] equal 1 returns the pointer to 0. Reads do not move the pointer.
- R3: Status at 0x04 has this layout: bit0 is FIFO not empty, bit1 is FIFO full, bit2 is transmit enable (transmit ready), bit3 is transmitter empty, and bits 7:4 are `rx_err[3:0]` (overrun, parity, framing, break).
- R4: A read at 0x0C returns `rx_head` and pulses `rx_pop` once if the FIFO is not empty. If the FIFO is empty, the read returns 0 and no pop is issued.
- R5: A write at 0x0C latches the byte. With transmit enabled, the byte appears on `tx_data` with `tx_valid` high for exactly the cycle after the write, and transmitter-empty stays set. With transmit disabled, transmitter-empty clears and nothing is issued.
- R6: Command bits [3:2] equal to 1 enable transmit and issue a pending byte. A value of 2 disables transmit, which clears transmit ready and keeps any pending byte.
- R7: Command bits [5:4] equal to 3 disable transmit, drop a pending byte and set transmitter-empty. A value of 2 disables receive and pulses `rx_flush` for one cycle.
- R8: Command bits [1:0] equal to 1 set `rx_en` and 2 clear it. The value 3 in the transmit field or the receive field changes nothing.
- R9: Interrupt status at 0x14 reads bit0 as transmit ready. Bit1 reads as FIFO full when mode register 0 bit6 is set, and as FIFO not empty otherwise. All other bits read 0.
- R10: A write at 0x14 sets the interrupt mask. `irq` is high exactly when interrupt status ANDed with the mask is non-zero, and it follows changes within the same cycle.
- R11: Writes to 0x04, 0x10 and unmapped offsets change nothing. Offsets 0x18 and 0x1C read the upper and lower divider parameters. Every other offset reads 0.
- R12: Within one command byte, the reset field acts first, then the transmit field, then the receive field. A reset followed by an enable in the same byte leaves that direction enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd`, 0 otherwise |
| irq | output | 1 | Level interrupt request |
| tx_valid | output | 1 | One-cycle pulse: byte on `tx_data` goes to the serializer |
| tx_data | output | 8 | Byte handed to the serializer |
| rx_en | output | 1 | Receiver enable toward the serializer |
| rx_empty | input | 1 | Receive FIFO holds no byte |
| rx_full | input | 1 | Receive FIFO is full |
| rx_head | input | 8 | Oldest byte in the receive FIFO |
| rx_err | input | 4 | Error flags: overrun, parity, framing, break |
| rx_pop | output | 1 | One-cycle pulse: remove the head byte |
| rx_flush | output | 1 | One-cycle pulse: empty the FIFO |

## Verification
Every register result lands in the cycle after the clock edge that takes the strobe. This covers `bus_rdata`, `tx_valid` with `tx_data`, `rx_pop`, `rx_flush` and `rx_en`. The bench drives each access at a falling edge and samples all of them at the next falling edge, before another access can disturb them. `irq` is combinational on registered state and on the FIFO flags. It is compared at that same falling edge against the updated model and the FIFO inputs that are still held, so a change of mask, mode bit or flag is seen without any added latency.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 4;
  localparam int NUM_MODE = 2;
  localparam int MODE_RXSEL_BIT = 6;

  localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_INT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_DIVH = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_DIVL = 6'h1C;

  typedef enum logic [1:0] {
    MISC_NOP, MISC_PTR_RST, MISC_RX_RST, MISC_TX_RST
  } misc_op_e;

  typedef enum logic [1:0] {
    DIR_NOP, DIR_ON, DIR_OFF, DIR_RSVD
  } dir_op_e;

  typedef struct packed {
    misc_op_e misc;
    dir_op_e  tx;
    dir_op_e  rx;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_ctl_pkg::*;
(
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_byte,
  output cmd_t              cmd
);
  // Fields are split out only when a command write is present, so a
  // quiet cycle always decodes as three no-ops.
  always_comb begin
    if (cmd_wr) begin
      cmd.misc = misc_op_e'(cmd_byte[5:4]);
      cmd.tx   = dir_op_e'(cmd_byte[3:2]);
      cmd.rx   = dir_op_e'(cmd_byte[1:0]);
    end else begin
      cmd.misc = MISC_NOP;
      cmd.tx   = DIR_NOP;
      cmd.rx   = DIR_NOP;
    end
  end
endmodule

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
  import uart_ctl_pkg::*;
#(
  parameter int NUM = NUM_MODE,
  localparam int PW = (NUM > 1) ? $clog2(NUM) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ptr_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] mode_first
);
  logic [PW-1:0]     ptr;
  logic [DATA_W-1:0] regs [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (wr_en && ptr == PW'(g)) regs[g] <= wdata;
    end
  end

  // Pointer steps forward after each write and sticks at the last register.
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ptr_clr) ptr <= '0;
    else if (wr_en && ptr != PW'(NUM-1)) ptr <= ptr + 1'b1;
  end

  assign rd_data    = regs[ptr];
  assign mode_first = regs[0];

  // R2: a write through the shared offset never leaves the pointer at 0
  p_ptr_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> (ptr != '0));
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              xmt_reset,
  output logic              tx_en,
  output logic              tx_empty,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  logic [DATA_W-1:0] buf_q;
  logic en_n, emp_n, issue;

  // Reset field first, then enable field, then buffer write; an issue
  // happens only on an enable or a buffer write.
  always_comb begin
    en_n  = tx_en;
    emp_n = tx_empty;
    if (xmt_reset) begin
      en_n  = 1'b0;
      emp_n = 1'b1;
    end
    if (en_set)      en_n = 1'b1;
    else if (en_clr) en_n = 1'b0;
    if (buf_wr)      emp_n = 1'b0;
    issue = (en_set || buf_wr) && en_n && !emp_n;
    if (issue) emp_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en    <= 1'b0;
      tx_empty <= 1'b1;
      tx_valid <= 1'b0;
      buf_q    <= '0;
      tx_data  <= '0;
    end else begin
      tx_en    <= en_n;
      tx_empty <= emp_n;
      tx_valid <= issue;
      if (buf_wr) buf_q <= buf_data;
      if (issue)  tx_data <= buf_wr ? buf_data : buf_q;
    end
  end

  // R6: an enabled transmitter never holds an unsent byte
  p_en_implies_empty_r6: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> tx_empty);
  // R5: an issued byte always leaves the holding register empty
  p_valid_empty_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_empty);
  // R7: a transmitter reset drops the byte and blocks issue
  p_reset_no_issue_r7: assert property (@(posedge clk) disable iff (rst)
    (xmt_reset && !en_set) |=> (!tx_valid && tx_empty));
endmodule

// File: rtl/uart_ctl_core.sv
module uart_ctl_core
  import uart_ctl_pkg::*;
#(
  parameter logic [7:0] DIVISOR_HI = 8'h00,
  parameter logic [7:0] DIVISOR_LO = 8'h1A
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              rx_en,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic [DATA_W-1:0] rx_head,
  input  logic [ERR_W-1:0]  rx_err,
  output logic              rx_pop,
  output logic              rx_flush
);
  logic wr_mode, wr_cmd, wr_tx, wr_int, rd_rxd;
  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
  assign wr_tx   = bus_wr && (bus_addr == OFS_DATA);
  assign wr_int  = bus_wr && (bus_addr == OFS_INT);
  assign rd_rxd  = bus_rd && (bus_addr == OFS_DATA);

  cmd_t cmd;
  uart_cmd_decode u_dec (
    .cmd_wr   (wr_cmd),
    .cmd_byte (bus_wdata),
    .cmd      (cmd)
  );

  logic [DATA_W-1:0] mode_rd, mode0;
  uart_mode_regs #(.NUM(NUM_MODE)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_mode),
    .wdata      (bus_wdata),
    .ptr_clr    (cmd.misc == MISC_PTR_RST),
    .rd_data    (mode_rd),
    .mode_first (mode0)
  );

  logic tx_en, tx_empty;
  uart_tx_hold u_tx (
    .clk       (clk),
    .rst       (rst),
    .buf_wr    (wr_tx),
    .buf_data  (bus_wdata),
    .en_set    (cmd.tx == DIR_ON),
    .en_clr    (cmd.tx == DIR_OFF),
    .xmt_reset (cmd.misc == MISC_TX_RST),
    .tx_en     (tx_en),
    .tx_empty  (tx_empty),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
  );

  // Receive enable: reset field first, then the receive field.
  logic rx_en_n;
  always_comb begin
    rx_en_n = rx_en;
    if (cmd.misc == MISC_RX_RST) rx_en_n = 1'b0;
    if (cmd.rx == DIR_ON)        rx_en_n = 1'b1;
    else if (cmd.rx == DIR_OFF)  rx_en_n = 1'b0;
  end

  logic [DATA_W-1:0] int_mask;
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en    <= 1'b0;
      int_mask <= '0;
      rx_pop   <= 1'b0;
      rx_flush <= 1'b0;
    end else begin
      rx_en    <= rx_en_n;
      if (wr_int) int_mask <= bus_wdata;
      rx_pop   <= rd_rxd && !rx_empty;
      rx_flush <= (cmd.misc == MISC_RX_RST);
    end
  end

  logic [DATA_W-1:0] status, int_stat;
  logic rx_src;
  assign status   = {rx_err, tx_empty, tx_en, rx_full, !rx_empty};
  assign rx_src   = mode0[MODE_RXSEL_BIT] ? rx_full : !rx_empty;
  assign int_stat = {{(DATA_W-2){1'b0}}, rx_src, tx_en};
  assign irq      = |(int_stat & int_mask);

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (bus_addr)
      OFS_MODE: rd_mux = mode_rd;
      OFS_STAT: rd_mux = status;
      OFS_DATA: rd_mux = rx_empty ? '0 : rx_head;
      OFS_INT:  rd_mux = int_stat;
      OFS_DIVH: rd_mux = DIVISOR_HI;
      OFS_DIVL: rd_mux = DIVISOR_LO;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : '0;
  end

  // R10: no interrupt while the mask is clear
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
    (int_mask == '0) |-> !irq);
  // R4: a pop only follows a data read of a non-empty FIFO
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> ($past(rd_rxd) && !$past(rx_empty)));
  // R7: a flush pulse follows only a receiver reset command
  p_flush_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    rx_flush |-> $past(wr_cmd));
  // R8: a reserved receive code holds the enable when no reset comes along
  p_rx_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd.rx == DIR_RSVD && cmd.misc != MISC_RX_RST) |=> $stable(rx_en));
endmodule

// File: tb/uart_ctl_core_bench.sv
module uart_ctl_core_bench;
  localparam logic [7:0] DHI = 8'h02;
  localparam logic [7:0] DLO = 8'h8B;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, tx_valid, rx_en, rx_pop, rx_flush;
  logic [7:0] tx_data;
  logic       rx_empty = 1'b1, rx_full = 1'b0;
  logic [7:0] rx_head = '0;
  logic [3:0] rx_err = '0;

  always #10 clk = ~clk;

  uart_ctl_core #(.DIVISOR_HI(DHI), .DIVISOR_LO(DLO)) u_uart_ctl_core (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .rx_en(rx_en),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_head(rx_head),
    .rx_err(rx_err), .rx_pop(rx_pop), .rx_flush(rx_flush)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_mr [2];
  bit         m_ptr, m_txen, m_txemp, m_rxen;
  logic [7:0] m_txbuf, m_imr;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {rx_err, m_txemp, m_txen, rx_full, !rx_empty};
  endfunction

  function automatic logic [7:0] m_isr();
    logic src;
    src = m_mr[0][6] ? rx_full : !rx_empty;
    return {6'b0, src, m_txen};
  endfunction

  function automatic logic [7:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_mr[m_ptr];
      6'h04: return m_status();
      6'h0C: return rx_empty ? 8'h00 : rx_head;
      6'h14: return m_isr();
      6'h18: return DHI;
      6'h1C: return DLO;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [5:0] a, input logic [7:0] d,
                         output bit txv, output logic [7:0] txd, output bit fl);
    txv = 0; txd = 0; fl = 0;
    case (a)
      6'h00: begin m_mr[m_ptr] = d; m_ptr = 1; end
      6'h08: begin
        case (d[5:4])
          2'd1: m_ptr = 0;
          2'd2: begin m_rxen = 0; fl = 1; end
          2'd3: begin m_txen = 0; m_txemp = 1; end
          default: ;
        endcase
        case (d[3:2])
          2'd1: begin
            m_txen = 1;
            if (!m_txemp) begin txv = 1; txd = m_txbuf; m_txemp = 1; end
          end
          2'd2: m_txen = 0;
          default: ;
        endcase
        case (d[1:0])
          2'd1: m_rxen = 1;
          2'd2: m_rxen = 0;
          default: ;
        endcase
      end
      6'h0C: begin
        m_txemp = 0; m_txbuf = d;
        if (m_txen) begin txv = 1; txd = d; m_txemp = 1; end
      end
      6'h14: m_imr = d;
      default: ;
    endcase
  endtask

  // One bus access, driven at a falling edge, results sampled one falling edge later.
  task automatic op(input bit w, input logic [5:0] a, input logic [7:0] d, input string tag);
    logic [7:0] e_rd, e_txd;
    bit e_txv, e_pop, e_fl;
    e_rd = 0; e_txv = 0; e_txd = 0; e_pop = 0; e_fl = 0;
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = !w;
    if (w) m_write(a, d, e_txv, e_txd, e_fl);
    else begin
      e_rd = m_read(a);
      e_pop = (a == 6'h0C) && !rx_empty;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk({tag, " rdata"}, bus_rdata, e_rd);
    chk({tag, " tx_valid"}, {7'b0, tx_valid}, {7'b0, e_txv});
    if (e_txv) chk({tag, " tx_data"}, tx_data, e_txd);
    chk({tag, " rx_pop"}, {7'b0, rx_pop}, {7'b0, e_pop});
    chk({tag, " rx_flush"}, {7'b0, rx_flush}, {7'b0, e_fl});
    chk({tag, " rx_en"}, {7'b0, rx_en}, {7'b0, m_rxen});
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, |(m_isr() & m_imr)});
  endtask

  task automatic fin();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      fin();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0; m_txen = 0; m_txemp = 1;
    m_rxen = 0; m_txbuf = 0; m_imr = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1 rx_en", {7'b0, rx_en}, 8'h00);
    chk("R1 rx_pop/flush", {6'b0, rx_pop, rx_flush}, 8'h00);
    op(0, 6'h04, 0, "R1 R3 status after reset");
    chk("R1 status literal", m_status(), 8'h08);
    op(0, 6'h00, 0, "R1 mode0");
    op(0, 6'h14, 0, "R1 isr");
    // R2 pointer
    op(1, 6'h00, 8'h40, "R2 write mode0");
    op(1, 6'h00, 8'h5A, "R2 write mode1");
    op(0, 6'h00, 0, "R2 read mode1");
    op(1, 6'h00, 8'hC3, "R2 rewrite mode1");
    op(1, 6'h08, 8'h10, "R2 pointer reset");
    op(0, 6'h00, 0, "R2 read mode0");
    op(0, 6'h00, 0, "R2 read does not advance");
    // R3 R4
    rx_empty = 0; rx_head = 8'hA5; rx_err = 4'b0101;
    op(0, 6'h04, 0, "R3 status with data and errors");
    op(0, 6'h0C, 0, "R4 data read pops");
    rx_empty = 1; rx_err = 0;
    op(0, 6'h0C, 0, "R4 empty read");
    // R5 R6
    op(1, 6'h0C, 8'h3C, "R5 write while disabled");
    op(0, 6'h04, 0, "R5 empty flag cleared");
    op(1, 6'h08, 8'h04, "R6 enable issues pending");
    op(1, 6'h0C, 8'h77, "R5 write while enabled");
    op(0, 6'h04, 0, "R5 status after send");
    op(1, 6'h08, 8'h08, "R6 disable");
    op(0, 6'h04, 0, "R6 ready cleared");
    // R7 R8
    op(1, 6'h0C, 8'h11, "R7 pending byte");
    op(1, 6'h08, 8'h30, "R7 reset transmitter");
    op(1, 6'h08, 8'h04, "R7 enable after drop");
    op(1, 6'h08, 8'h01, "R8 receive enable");
    op(1, 6'h08, 8'h03, "R8 reserved rx code");
    op(1, 6'h08, 8'h0C, "R8 reserved tx code");
    op(0, 6'h04, 0, "R8 tx unchanged");
    op(1, 6'h08, 8'h20, "R7 reset receiver");
    op(1, 6'h08, 8'h02, "R8 receive disable");
    // R12 ordering
    op(1, 6'h08, 8'h21, "R12 rx reset then enable");
    op(1, 6'h08, 8'h34, "R12 tx reset then enable");
    // R9 R10 (mode0 currently 0x40: full selects)
    op(1, 6'h08, 8'h08, "R10 tx off");
    rx_empty = 0; rx_full = 0;
    op(1, 6'h14, 8'h02, "R9 mask rx, full-select, not full");
    rx_full = 1;
    op(0, 6'h14, 0, "R9 full-select full");
    rx_full = 0;
    op(1, 6'h08, 8'h10, "R9 pointer reset");
    op(1, 6'h00, 8'h00, "R9 ready-select");
    op(0, 6'h14, 0, "R9 isr ready-select");
    op(1, 6'h14, 8'h01, "R10 mask tx only, tx off");
    op(1, 6'h08, 8'h04, "R10 tx on raises irq");
    op(1, 6'h14, 8'h00, "R10 mask clear");
    // R11 ignored writes and decode
    op(1, 6'h04, 8'hFF, "R11 write status ignored");
    op(1, 6'h10, 8'hFF, "R11 write aux ignored");
    op(1, 6'h2C, 8'hFF, "R11 write unmapped ignored");
    op(0, 6'h00, 0, "R11 mode after ignored writes");
    op(0, 6'h04, 0, "R11 status after ignored writes");
    op(0, 6'h14, 0, "R11 isr after ignored writes");
    op(0, 6'h18, 0, "R11 divider high");
    op(0, 6'h1C, 0, "R11 divider low");
    op(0, 6'h08, 0, "R11 command reads zero");
    op(0, 6'h10, 0, "R11 aux reads zero");
    op(0, 6'h3F, 0, "R11 unmapped reads zero");
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [5:0] a;
      logic [31:0] r;
      r = $urandom;
      rx_empty = r[0];
      rx_full  = !r[0] && r[1];
      rx_head  = r[15:8];
      rx_err   = r[19:16];
      case ($urandom % 10)
        0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h08;
        4: a = 6'h0C; 5: a = 6'h10; 6: a = 6'h14; 7: a = 6'h18;
        8: a = 6'h1C; default: a = 6'($urandom);
      endcase
      op(1'($urandom), a, 8'($urandom), "R2-R12 random");
    end
    done = 1'b1;
    fin();
  end
endmodule